// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block translates the 128 logical general-register numbers seen by an instruction into physical register indices. The low 32 logical registers are fixed and always map to themselves. The upper 96 form a sliding window whose start is a physical base pointer. A frame marker describes the current window: its total size, how many of its registers are inputs plus locals, a rotating sub-region size and a rotating offset. One saved copy of the marker lets a callee return to its caller.

Four commands change the state. An allocate command sizes the frame. A call command slides the window so that the caller's first output register becomes the callee's register 32. A return command brings back the caller's frame. A rotate command steps the rotating offset, so that a value written in one loop iteration is read one register higher in the next. A combinational lookup port gives the physical index for any logical register. It also flags a stacked register that lies outside the current frame. Spilling to memory is not modelled: the physical stacked file is assumed large enough, and its index wraps around at its power-of-two size.

Top module: `rsf_renamer`

## Requirements
- R1: A logical register below 32 gives lk_phys = {1'b0, register number zero-extended} and lk_err = 0, whatever the frame state.
- R2: A stacked register r (32..127) with offset o = r-32 outside the rotating region gives lk_phys = {1'b1, (base + o) mod 2^STK_W}.
- R3: A stacked register with offset o at or above the current frame size gives lk_err = 1. A register inside the frame gives lk_err = 0.
- R4: An allocate command (cmd_op = 0) with counts i, l, o and rotating count k sets locals size to i+l and frame size to i+l+o. It sets the rotating size to 8k and clears the rotating offset. It is ignored if i+l+o exceeds 96 or 8k exceeds i+l+o.
- R5: A call command (cmd_op = 1) saves the whole marker as the previous marker. It advances base by the locals size and sets the frame size to frame size minus locals size, with locals, rotating size and offset all zero. The caller's register 32+locals becomes the callee's register 32.
- R6: A return command (cmd_op = 2) restores the saved marker and moves base back by the restored locals size. A caller's lookups then read as they did before the call.
- R7: Inside a rotating region of size S = 8k > 0, offset o < S maps to base + ((o + rrb) mod S). A rotate command (cmd_op = 3) changes rrb to rrb-1, or to S-1 when rrb is 0.
- R8: A rotate command while the rotating size is 0 has no effect on any lookup.
- R9: After reset, base is 0, all marker fields are 0 and every stacked register reports lk_err = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | 0 allocate, 1 call, 2 return, 3 rotate |
| cmd_ins | input | 7 | Allocate: input count |
| cmd_loc | input | 7 | Allocate: local count |
| cmd_out | input | 7 | Allocate: output count |
| cmd_rot | input | 4 | Allocate: rotating size in units of 8 registers |
| lk_reg | input | 7 | Logical register to translate |
| lk_phys | output | STK_W+1 | Physical index; MSB set for the stacked file |
| lk_err | output | 1 | Stacked register outside the current frame |

## Verification
The bench builds the block with STK_W = 7, so the stacked file holds only 128 entries. A few hundred random calls and returns then carry the base pointer past its wrap point many times, which checks the modular base arithmetic of R2, R5 and R6. Random allocations with rotating counts up to 3 bring sizes of 8, 16 and 24 and both rejection rules of R4 within reach. Repeated rotates then cycle the offset through its wrap from 0 to S-1.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int LREG_W   = 7;
  localparam int STATIC_N = 32;
  localparam int STACK_N  = (1 << LREG_W) - STATIC_N;

  typedef enum logic [1:0] {
    OP_ALLOC = 2'd0,
    OP_CALL  = 2'd1,
    OP_RET   = 2'd2,
    OP_ROT   = 2'd3
  } op_e;

  typedef struct packed {
    logic [LREG_W-1:0] sof;
    logic [LREG_W-1:0] sol;
    logic [3:0]        sor;
    logic [LREG_W-1:0] rrb;
  } marker_t;
endpackage

// File: rtl/rsf_marker.sv
module rsf_marker
  import rsf_pkg::*;
#(
  parameter int STK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  op_e               cmd_op,
  input  logic [LREG_W-1:0] cmd_ins,
  input  logic [LREG_W-1:0] cmd_loc,
  input  logic [LREG_W-1:0] cmd_out,
  input  logic [3:0]        cmd_rot,
  output marker_t           cfm_o,
  output logic [STK_W-1:0]  base_o
);
  localparam int SUM_W = LREG_W + 2;

  marker_t          cfm_q, cfm_d, pfm_q, pfm_d;
  logic [STK_W-1:0] base_q, base_d;
  logic             upd_en;
  logic [SUM_W-1:0] w_loc, w_tot, w_rsz;
  logic [LREG_W-1:0] cur_rsz;

  always_comb begin
    w_loc   = SUM_W'(cmd_ins) + SUM_W'(cmd_loc);
    w_tot   = w_loc + SUM_W'(cmd_out);
    w_rsz   = SUM_W'({cmd_rot, 3'b000});
    cur_rsz = {cfm_q.sor, 3'b000};
    cfm_d   = cfm_q;
    pfm_d   = pfm_q;
    base_d  = base_q;
    upd_en  = cmd_vld;
    if (cmd_vld) begin
      case (cmd_op)
        OP_ALLOC: begin
          if (w_tot <= SUM_W'(STACK_N) && w_rsz <= w_tot) begin
            cfm_d.sof = w_tot[LREG_W-1:0];
            cfm_d.sol = w_loc[LREG_W-1:0];
            cfm_d.sor = cmd_rot;
            cfm_d.rrb = '0;
          end
        end
        OP_CALL: begin
          pfm_d     = cfm_q;
          cfm_d.sof = cfm_q.sof - cfm_q.sol;
          cfm_d.sol = '0;
          cfm_d.sor = '0;
          cfm_d.rrb = '0;
          base_d    = base_q + STK_W'(cfm_q.sol);
        end
        OP_RET: begin
          cfm_d  = pfm_q;
          base_d = base_q - STK_W'(pfm_q.sol);
        end
        default: begin
          if (cfm_q.sor != 4'd0)
            cfm_d.rrb = (cfm_q.rrb == '0) ? cur_rsz - 7'd1 : cfm_q.rrb - 7'd1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfm_q  <= '0;
      pfm_q  <= '0;
      base_q <= '0;
    end else if (upd_en) begin
      cfm_q  <= cfm_d;
      pfm_q  <= pfm_d;
      base_q <= base_d;
    end
  end

  assign cfm_o  = cfm_q;
  assign base_o = base_q;

  // R5
  call_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == OP_CALL) |=>
      (base_q == $past(base_q) + STK_W'($past(cfm_q.sol)) && cfm_q.sol == '0));

  // R6
  ret_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == OP_RET) |=> (base_q == $past(base_q) - STK_W'(cfm_q.sol)));

  // R7
  rrb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfm_q.sor != 4'd0) |-> (cfm_q.rrb < {cfm_q.sor, 3'b000}));

  // R8
  rot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == OP_ROT && cfm_q.sor == 4'd0) |=> $stable(cfm_q));

  // R4
  frame_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfm_q.sol <= cfm_q.sof) && (cfm_q.sof <= 7'(STACK_N)));
endmodule

// File: rtl/rsf_xlate.sv
module rsf_xlate
  import rsf_pkg::*;
#(
  parameter int STK_W = 9
) (
  input  marker_t           cfm,
  input  logic [STK_W-1:0]  base,
  input  logic [LREG_W-1:0] lk_reg,
  output logic [STK_W:0]    lk_phys,
  output logic              lk_err
);
  logic              stacked;
  logic [LREG_W-1:0] off, rsz, idx;
  logic [LREG_W:0]   sum, wrapped;

  always_comb begin
    stacked = lk_reg >= LREG_W'(STATIC_N);
    off     = lk_reg - LREG_W'(STATIC_N);
    rsz     = {cfm.sor, 3'b000};
    sum     = {1'b0, off} + {1'b0, cfm.rrb};
    wrapped = (sum >= {1'b0, rsz}) ? sum - {1'b0, rsz} : sum;
    idx     = (off < rsz) ? wrapped[LREG_W-1:0] : off;
    lk_err  = stacked && (off >= cfm.sof);
    if (stacked)
      lk_phys = {1'b1, base + STK_W'(idx)};
    else
      lk_phys = {1'b0, STK_W'(lk_reg[4:0])};
  end
endmodule

// File: rtl/rsf_renamer.sv
module rsf_renamer
  import rsf_pkg::*;
#(
  parameter int STK_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [6:0]       cmd_ins,
  input  logic [6:0]       cmd_loc,
  input  logic [6:0]       cmd_out,
  input  logic [3:0]       cmd_rot,
  input  logic [6:0]       lk_reg,
  output logic [STK_W:0]   lk_phys,
  output logic             lk_err
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  marker_t          cfm;
  logic [STK_W-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rsf_marker #(.STK_W(STK_W)) u_marker (
    .clk     (clk),
    .rst_n   (rst_ni),
    .cmd_vld (cmd_valid),
    .cmd_op  (op_e'(cmd_op)),
    .cmd_ins (cmd_ins),
    .cmd_loc (cmd_loc),
    .cmd_out (cmd_out),
    .cmd_rot (cmd_rot),
    .cfm_o   (cfm),
    .base_o  (base)
  );

  rsf_xlate #(.STK_W(STK_W)) u_xlate (
    .cfm     (cfm),
    .base    (base),
    .lk_reg  (lk_reg),
    .lk_phys (lk_phys),
    .lk_err  (lk_err)
  );

  // R3
  err_static_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    lk_err |-> (lk_reg >= 7'd32));

  // R1
  static_side_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (lk_reg < 7'd32) |-> (!lk_phys[STK_W] && !lk_err));
endmodule

// File: tb/tb_rsf_renamer.sv
`timescale 1ns/100ps
module tb_rsf_renamer;
  localparam int STK_W = 7;
  localparam int MASK  = (1 << STK_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic [6:0] cmd_ins, cmd_loc, cmd_out;
  logic [3:0] cmd_rot;
  logic [6:0] lk_reg;
  logic [STK_W:0] lk_phys;
  logic lk_err;

  int checks = 0;
  int errors = 0;

  int m_base, m_sof, m_sol, m_sor, m_rrb;
  int p_sof, p_sol, p_sor, p_rrb;

  always #2 clk = ~clk;

  rsf_renamer #(.STK_W(STK_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ins(cmd_ins), .cmd_loc(cmd_loc), .cmd_out(cmd_out), .cmd_rot(cmd_rot),
    .lk_reg(lk_reg), .lk_phys(lk_phys), .lk_err(lk_err)
  );

  function automatic int exp_phys(int r);
    int o, s;
    if (r < 32) return r;
    o = r - 32;
    s = m_sor * 8;
    if (o < s) o = (o + m_rrb) % s;
    return (1 << STK_W) | ((m_base + o) & MASK);
  endfunction

  function automatic bit exp_err(int r);
    return (r >= 32) && ((r - 32) >= m_sof);
  endfunction

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic look(input int r, input string tag);
    @(negedge clk);
    lk_reg = 7'(r);
    #0.5;
    checks++;
    if (lk_err !== exp_err(r)) begin
      errors++;
      $display("FAIL %s reg %0d err actual %0b expected %0b", tag, r, lk_err, exp_err(r));
    end else if (!exp_err(r) && lk_phys !== (STK_W+1)'(exp_phys(r))) begin
      errors++;
      $display("FAIL %s reg %0d phys actual %0d expected %0d", tag, r, lk_phys, exp_phys(r));
    end
  endtask

  task automatic model(input int op, input int i, input int l, input int o, input int k);
    int t;
    case (op)
      0: begin
        t = i + l + o;
        if (t <= 96 && k * 8 <= t) begin
          m_sof = t; m_sol = i + l; m_sor = k; m_rrb = 0;
        end
      end
      1: begin
        p_sof = m_sof; p_sol = m_sol; p_sor = m_sor; p_rrb = m_rrb;
        m_base = (m_base + m_sol) & MASK;
        m_sof = m_sof - m_sol; m_sol = 0; m_sor = 0; m_rrb = 0;
      end
      2: begin
        m_sof = p_sof; m_sol = p_sol; m_sor = p_sor; m_rrb = p_rrb;
        m_base = (m_base - m_sol) & MASK;
      end
      default: if (m_sor != 0) m_rrb = (m_rrb == 0) ? m_sor * 8 - 1 : m_rrb - 1;
    endcase
  endtask

  task automatic cmd(input int op, input int i, input int l, input int o, input int k);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op);
    cmd_ins = 7'(i); cmd_loc = 7'(l); cmd_out = 7'(o); cmd_rot = 4'(k);
    @(negedge clk);
    cmd_valid = 1'b0;
    model(op, i, l, o, k);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int seed;
    int saved;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
    cmd_ins = '0; cmd_loc = '0; cmd_out = '0; cmd_rot = '0; lk_reg = '0;
    m_base = 0; m_sof = 0; m_sol = 0; m_sor = 0; m_rrb = 0;
    p_sof = 0; p_sol = 0; p_sor = 0; p_rrb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state, R1 static identity
    look(5, "R9/R1");
    look(31, "R1");
    look(32, "R9");
    look(127, "R9");

    // R4 allocate 2 inputs, 12 locals, 7 outputs: frame 21, locals 14
    cmd(0, 2, 12, 7, 0);
    look(52, "R4");
    look(53, "R3");
    look(40, "R2");
    look(46, "R5");
    saved = int'(lk_phys);
    // R5 call: caller r46 becomes callee r32
    cmd(1, 0, 0, 0, 0);
    look(32, "R5");
    checks++;
    if (int'(lk_phys) != saved) begin
      errors++;
      $display("FAIL R5 callee r32 actual %0d expected %0d", lk_phys, saved);
    end
    look(38, "R5");
    look(39, "R3");
    // R6 return
    cmd(2, 0, 0, 0, 0);
    look(46, "R6");
    look(52, "R6");
    look(53, "R6");

    // R4 rejections
    cmd(0, 40, 40, 40, 0);
    look(52, "R4");
    cmd(0, 0, 4, 0, 1);
    look(52, "R4");

    // R7 rotating region of 8 within 16-register frame
    cmd(0, 0, 16, 0, 1);
    look(32, "R7");
    cmd(3, 0, 0, 0, 0);
    look(32, "R7");
    look(39, "R7");
    look(40, "R2");
    for (int n = 0; n < 7; n++) cmd(3, 0, 0, 0, 0);
    look(32, "R7");
    look(35, "R7");

    // R8 rotate with rotating size zero
    cmd(0, 0, 10, 0, 0);
    cmd(3, 0, 0, 0, 0);
    look(32, "R8");
    look(41, "R8");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op, pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 3) op = 0;
      else if (pick < 5) op = 1;
      else if (pick < 7) op = 2;
      else op = 3;
      if (op == 0 && $urandom_range(0, 9) == 0)
        cmd(0, int'($urandom_range(20, 60)), int'($urandom_range(20, 60)), int'($urandom_range(0, 20)), 0);
      else
        cmd(op, int'($urandom_range(0, 7)), int'($urandom_range(0, 15)),
            int'($urandom_range(0, 15)), int'($urandom_range(0, 3)));
      for (int q = 0; q < 3; q++) begin
        int r;
        r = (q == 0) ? int'($urandom_range(0, 127)) : 32 + int'($urandom_range(0, 40));
        look(r, "R2/R3/R5/R6/R7 random");
      end
    end

    report();
  end
endmodule